// File: doc/BRIEF.md
# Set/Clear Programmed Edge and Level Interrupt Controller

This block gathers up to 32 interrupt inputs and turns them into two request lines for a processor. Software programs each input through a small word-addressed register port. Each input is set to one of five trigger modes: rising edge, falling edge, active-high level, active-low level or off. Each input is also steered to one of the two request lines and enabled by a mask bit. Every control register has a pair of write addresses, one that sets bits and one that clears them. A driver can therefore change one source without a read-modify-write cycle.

Raw inputs are synchronized before use. Edges are captured in two sticky registers, one for rising and one for falling, which software acknowledges by bit. A level source follows its synchronized input with the polarity corrected. Software can read, for each request line, the vector of sources that are active, unmasked and routed to that line. Each request output is the registered OR of that vector.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: After reset every register reads 0, every status vector reads 0, and both request outputs are low.
- R2: Word addresses 2k and 2k+1 set and clear control register k: trigger bit 0 (k=0), trigger bit 1 (k=1), trigger bit 2 (k=2), route (k=3), source enable (k=4), mask (k=5) and wake (k=6). A 1 in the write data changes that bit, a 0 leaves it alone, and a read at either address returns the register.
- R3: The trigger code of a source is {bit2,bit1,bit0}: 3'b001 is rising edge, 3'b010 is falling edge, 3'b101 is active-high level and 3'b110 is active-low level.
- R4: Any other trigger code leaves the source off. It is never active and latches no edge.
- R5: In an edge mode, a matching edge of the synchronized input sets a sticky pending bit. The bit stays set after the input returns to idle, until a 1 is written to that bit at address 14 (rising) or address 15 (falling). Reads at 14 and 15 return the rising and falling pending vectors.
- R6: In a level mode, a source is active exactly while its synchronized input is at the active level, with no latching.
- R7: A source whose route bit is 1 drives request 0, and a source whose route bit is 0 drives request 1.
- R8: A source contributes to a request only while its mask bit is 1. The mask reads back unchanged so that software can save and restore it.
- R9: A read at address 16 returns active & mask & route, and a read at address 17 returns active & mask & ~route.
- R10: Each request output is the registered OR of its status vector. A level change on the input reaches the output on the 3rd rising clock edge after it, and an edge source reaches it on the 4th.
- R11: If a clear write and a new matching edge on the same source fall in the same cycle, the pending bit stays set.
- R12: The source-enable and wake registers are stored and read back, but they have no effect on status or request outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register word address |
| we_i | input | 1 | Write strobe for the current address |
| wdata_i | input | N_SRC | Write data, one bit per source |
| rdata_o | output | N_SRC | Combinational read data for addr_i |
| irq_i | input | N_SRC | Raw asynchronous interrupt inputs |
| req0_o | output | 1 | Registered request line 0 |
| req1_o | output | 1 | Registered request line 1 |

## Verification
The bench drives an edge into a source that is already pending in the same cycle as the software clear. A design in which the clear wins would lose that second interrupt. It parks sources on invalid trigger codes and toggles their inputs, so a decoder that treats one bit as the mode would give spurious requests. It lets an edge-mode input return to idle and checks that the pending bit survives, and it checks an active-low source on both levels to catch an inverted polarity. It counts clock edges from an input change to each request output, which exposes a missing or an extra synchronizer stage.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_AW  = 5;
  localparam int NUM_CTL = 7;

  localparam int CTL_CFG0  = 0;
  localparam int CTL_CFG1  = 1;
  localparam int CTL_CFG2  = 2;
  localparam int CTL_ROUTE = 3;
  localparam int CTL_EN    = 4;
  localparam int CTL_MASK  = 5;
  localparam int CTL_WAKE  = 6;

  localparam logic [REG_AW-1:0] A_RISE_ACK = 5'd14;
  localparam logic [REG_AW-1:0] A_FALL_ACK = 5'd15;
  localparam logic [REG_AW-1:0] A_STAT0    = 5'd16;
  localparam logic [REG_AW-1:0] A_STAT1    = 5'd17;

  typedef enum logic [2:0] {
    TRIG_OFF, TRIG_RISE, TRIG_FALL, TRIG_HIGH, TRIG_LOW
  } trig_e;

  function automatic trig_e decode_trig(input logic [2:0] code);
    case (code)
      3'b001:  return TRIG_RISE;
      3'b010:  return TRIG_FALL;
      3'b101:  return TRIG_HIGH;
      3'b110:  return TRIG_LOW;
      default: return TRIG_OFF;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (set_i) q_o <= q_o | wdata_i;
    else if (clr_i) q_o <= q_o & ~wdata_i;
  end
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [2:0] code_i,
  input  logic       rise_ack_i,
  input  logic       fall_ack_i,
  output logic       active_o,
  output logic       rise_o,
  output logic       fall_o
);
  trig_e mode;
  logic  prev_q, rise_hit, fall_hit;

  assign mode     = decode_trig(code_i);
  assign rise_hit = (mode == TRIG_RISE) &  lvl_i & ~prev_q;
  assign fall_hit = (mode == TRIG_FALL) & ~lvl_i &  prev_q;

  // a fresh edge beats an acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      rise_o <= rise_hit | (rise_o & ~rise_ack_i);
      fall_o <= fall_hit | (fall_o & ~fall_ack_i);
    end
  end

  always_comb begin
    case (mode)
      TRIG_RISE: active_o = rise_o;
      TRIG_FALL: active_o = fall_o;
      TRIG_HIGH: active_o = lvl_i;
      TRIG_LOW:  active_o = ~lvl_i;
      default:   active_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  input  logic [N_SRC-1:0]  irq_i,
  output logic              req0_o,
  output logic              req1_o
);
  logic [N_SRC-1:0] ctl_q [NUM_CTL];
  logic [N_SRC-1:0] lvl_s, active, rise_q, fall_q, rise_ack, fall_ack;
  logic [N_SRC-1:0] cfg0_q, cfg1_q, cfg2_q, route_q, mask_q, vec0, vec1;

  irq_sync #(.W(N_SRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(lvl_s)
  );

  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    irq_setclr_reg #(.W(N_SRC)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (we_i && (addr_i == REG_AW'(2*k))),
      .clr_i  (we_i && (addr_i == REG_AW'(2*k+1))),
      .wdata_i(wdata_i),
      .q_o    (ctl_q[k])
    );
  end

  assign cfg0_q  = ctl_q[CTL_CFG0];
  assign cfg1_q  = ctl_q[CTL_CFG1];
  assign cfg2_q  = ctl_q[CTL_CFG2];
  assign route_q = ctl_q[CTL_ROUTE];
  assign mask_q  = ctl_q[CTL_MASK];

  assign rise_ack = (we_i && addr_i == A_RISE_ACK) ? wdata_i : '0;
  assign fall_ack = (we_i && addr_i == A_FALL_ACK) ? wdata_i : '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_src_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl_s[i]),
      .code_i    ({cfg2_q[i], cfg1_q[i], cfg0_q[i]}),
      .rise_ack_i(rise_ack[i]),
      .fall_ack_i(fall_ack[i]),
      .active_o  (active[i]),
      .rise_o    (rise_q[i]),
      .fall_o    (fall_q[i])
    );
  end

  assign vec0 = active & mask_q &  route_q;
  assign vec1 = active & mask_q & ~route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req0_o <= 1'b0;
      req1_o <= 1'b0;
    end else begin
      req0_o <= |vec0;
      req1_o <= |vec1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < 5'd14) rdata_o = ctl_q[addr_i[3:1]];
    else begin
      case (addr_i)
        A_RISE_ACK: rdata_o = rise_q;
        A_FALL_ACK: rdata_o = fall_q;
        A_STAT0:    rdata_o = vec0;
        A_STAT1:    rdata_o = vec1;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_trigger_ctrl_chk.sv
module irq_trigger_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [N_SRC-1:0]  wdata_i,
  input logic [N_SRC-1:0]  cfg0_q,
  input logic [N_SRC-1:0]  cfg1_q,
  input logic [N_SRC-1:0]  cfg2_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  active,
  input logic [N_SRC-1:0]  rise_q,
  input logic [N_SRC-1:0]  vec0,
  input logic [N_SRC-1:0]  vec1,
  input logic              req0_o,
  input logic              req1_o
);
  logic [N_SRC-1:0] bad_code, ack_vec;

  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      bad_code[i] = !((cfg2_q[i] ^ cfg1_q[i] ^ cfg0_q[i]) == 1'b1 && !(cfg2_q[i] && cfg1_q[i] && cfg0_q[i])
                      ? (cfg1_q[i] ^ cfg0_q[i]) : (cfg2_q[i] && (cfg1_q[i] ^ cfg0_q[i])));
  end
  assign ack_vec = (we_i && addr_i == A_RISE_ACK) ? wdata_i : '0;

  p_off_src_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active & bad_code) == '0);
  p_mask_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vec0 | vec1) & ~mask_q) == '0);
  p_route_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec0 & vec1) == '0);
  p_req0_reg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> req0_o == $past(|vec0));
  p_req1_reg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> req1_o == $past(|vec1));
  p_rise_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(rise_q) & ~rise_q & ~$past(ack_vec)) == '0);
endmodule

bind irq_trigger_ctrl irq_trigger_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .cfg0_q(cfg0_q), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .mask_q(mask_q),
  .active(active), .rise_q(rise_q), .vec0(vec0), .vec1(vec1),
  .req0_o(req0_o), .req1_o(req1_o)
);

// File: tb/irq_trigger_ctrl_tb_top.sv
module irq_trigger_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   addr = '0;
  logic         we = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] irq = '0;
  logic         req0, req1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [N-1:0] m_c0 = '0, m_c1 = '0, m_c2 = '0, m_route = '0, m_en = '0;
  logic [N-1:0] m_mask = '0, m_wake = '0, m_rise = '0, m_fall = '0, m_irq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_trigger_ctrl #(.N_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_i(irq), .req0_o(req0), .req1_o(req1)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void model_wr(input logic [4:0] a, input logic [N-1:0] d);
    case (a)
      5'd0: m_c0 |= d;     5'd1: m_c0 &= ~d;
      5'd2: m_c1 |= d;     5'd3: m_c1 &= ~d;
      5'd4: m_c2 |= d;     5'd5: m_c2 &= ~d;
      5'd6: m_route |= d;  5'd7: m_route &= ~d;
      5'd8: m_en |= d;     5'd9: m_en &= ~d;
      5'd10: m_mask |= d;  5'd11: m_mask &= ~d;
      5'd12: m_wake |= d;  5'd13: m_wake &= ~d;
      5'd14: m_rise &= ~d; 5'd15: m_fall &= ~d;
      default: ;
    endcase
  endfunction

  function automatic logic [2:0] code_of(input int i);
    return {m_c2[i], m_c1[i], m_c0[i]};
  endfunction

  function automatic void model_irq(input logic [N-1:0] nv);
    for (int i = 0; i < N; i++) begin
      if (code_of(i) == 3'b001 && !m_irq[i] && nv[i]) m_rise[i] = 1'b1;
      if (code_of(i) == 3'b010 && m_irq[i] && !nv[i]) m_fall[i] = 1'b1;
    end
    m_irq = nv;
  endfunction

  function automatic logic [N-1:0] exp_active();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      case (code_of(i))
        3'b001: v[i] = m_rise[i];
        3'b010: v[i] = m_fall[i];
        3'b101: v[i] = m_irq[i];
        3'b110: v[i] = ~m_irq[i];
        default: v[i] = 1'b0;
      endcase
    end
    return v;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic drive_irq(input logic [N-1:0] nv);
    @(negedge clk); irq = nv;
    model_irq(nv);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [N-1:0] d, e;
    e = exp_active();
    rd(5'd16, d); chk({tag, " R9 stat0"}, d, e & m_mask & m_route);
    rd(5'd17, d); chk({tag, " R9 stat1"}, d, e & m_mask & ~m_route);
    chk({tag, " R10 req0"}, N'(req0), N'(|(e & m_mask & m_route)));
    chk({tag, " R10 req1"}, N'(req1), N'(|(e & m_mask & ~m_route)));
    rd(5'd14, d); chk({tag, " R5 rise"}, d, m_rise);
    rd(5'd15, d); chk({tag, " R5 fall"}, d, m_fall);
    rd(5'd10, d); chk({tag, " R8 mask"}, d, m_mask);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 18; a++) begin
      rd(5'(a), d); chk("R1 reset read", d, '0);
    end
    chk("R1 req0", N'(req0), '0);
    chk("R1 req1", N'(req1), '0);

    // R2 set/clear only touches written ones
    wr(5'd12, 32'hF0F0_1234); wr(5'd13, 32'h1000_0030);
    rd(5'd12, d); chk("R2 wake set/clr", d, 32'hE0F0_1204);
    rd(5'd13, d); chk("R2 read clr addr", d, 32'hE0F0_1204);

    // R10 latency: src0 high level -> req0, src1 rising -> req1
    wr(5'd0, 32'h3); wr(5'd4, 32'h1); wr(5'd2, 32'h0);
    wr(5'd6, 32'h1); wr(5'd10, 32'h3);
    settle();
    drive_irq(32'h3);
    @(negedge clk); chk("R10 req0 e1", N'(req0), '0);
    @(negedge clk); chk("R10 req0 e2", N'(req0), '0);
    @(negedge clk); chk("R10 req0 e3", N'(req0), 1); chk("R10 req1 e3", N'(req1), '0);
    @(negedge clk); chk("R10 req1 e4", N'(req1), 1);
    settle(); check_all("R3 R6 R7 latency");

    // R5 pending survives return to idle
    drive_irq(32'h0); settle();
    check_all("R5 idle");
    rd(5'd14, d); chk("R5 held", d[1], 1'b1);

    // R11 clear coincides with a new edge on a pending source
    @(negedge clk); irq = 32'h2;
    @(negedge clk);
    @(negedge clk); addr = 5'd14; we = 1'b1; wdata = 32'h2;
    @(negedge clk); we = 1'b0;
    model_irq(32'h2);
    rd(5'd14, d); chk("R11 edge wins", d[1], 1'b1);
    wr(5'd14, 32'h2);
    rd(5'd14, d); chk("R5 clear", d[1], 1'b0);
    drive_irq(32'h0); settle();

    // R3 R6 active-low and falling on src2/src3
    wr(5'd2, 32'hC); wr(5'd4, 32'h4); wr(5'd1, 32'h8); wr(5'd0, 32'h4); wr(5'd1, 32'h4);
    wr(5'd0, 32'h0); wr(5'd10, 32'hC);
    settle(); check_all("R6 low idle");
    drive_irq(32'hC); settle(); check_all("R6 low high");
    drive_irq(32'h0); settle(); check_all("R3 fall");

    // R4 invalid codes on src4..7: 111, 011, 100, 000
    wr(5'd0, 32'h30); wr(5'd2, 32'h30); wr(5'd4, 32'h50); wr(5'd10, 32'hF0);
    drive_irq(32'hF0); settle(); drive_irq(32'h0); settle();
    rd(5'd16, d); chk("R4 off stat0", d & 32'hF0, '0);
    rd(5'd17, d); chk("R4 off stat1", d & 32'hF0, '0);
    rd(5'd14, d); chk("R4 no rise", d & 32'hF0, '0);
    rd(5'd15, d); chk("R4 no fall", d & 32'hF0, '0);

    // R12 enable/wake have no effect
    wr(5'd8, '1); wr(5'd12, '1); settle(); check_all("R12 en wake on");
    wr(5'd9, '1); wr(5'd13, '1); settle(); check_all("R12 en wake off");

    // random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom % 3 == 0) drive_irq(m_irq ^ N'($urandom));
      else wr(5'($urandom % 18), N'($urandom));
      settle();
      check_all("R2 R3 R4 R6 R7 R8 R9 R12 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule